// File: doc/BRIEF.md
# PCI 4 KB Memory Base Address Register

This block is one 32-bit base address register of a PCI target that claims a single 4 KB window in 32-bit memory space. Configuration software reaches it through a small single-cycle access port: a write strobe with four byte lane enables, and a read strobe that returns the register contents combinationally in the same cycle.

Software sizes the window in two passes. First it writes all ones. It then reads back `0xFFFFF000`. The lowest bit that stayed set is bit 12, which gives a 4 KB window. Software then writes the base address it has chosen. The low twelve bits are constants and are not storage. They report a 32-bit, non-prefetchable memory window, and nothing written to them is kept. Once memory decoding is enabled, the block compares each bus address phase that carries a memory read or memory write command against the stored upper twenty bits. It raises a registered hit flag one clock later.

Top module: `pci_mem_bar`

## Requirements
- R1: After reset the stored base bits 31:12 are zero, a read returns `0x00000000`, and `addrHit` is low.
- R2: A write of `0xFFFFFFFF` with all four byte enables set, followed by a read, returns `0xFFFFF000`.
- R3: Read bits 11:0 are always zero, whatever was written to them. Bit 0 = 0 (memory space), bits 2:1 = 00 (32-bit placement), bit 3 = 0 (not prefetchable).
- R4: `cfgRdData` carries the register value in the same cycle `cfgRdEn` is high. It is `0x00000000` in any cycle where `cfgRdEn` is low.
- R5: Byte enable bit n (n = 0..3) gates data bits 8n+7:8n. Lanes whose enable is low leave their stored bits unchanged. Lane 0 holds no storage, so a write with only `cfgByteEn[0]` set changes nothing.
- R6: After a full write of value V, a read returns V with bits 11:0 cleared.
- R7: `addrHit` is high in the cycle after an address phase when all of the following hold: `memSpaceEn` is high, `busCmd` is 4'h6 (memory read) or 4'h7 (memory write), and `busAddr[31:12]` equals the stored bits 31:12.
- R8: `addrHit` is low in the cycle after any cycle where `memSpaceEn` is low.
- R9: `addrHit` is low in the cycle after any cycle where `busCmd` is neither 4'h6 nor 4'h7. Examples are 4'h2 (I/O read) and 4'hA (configuration read).
- R10: With base B, addresses B and B+0xFFF hit, while B-1 and B+0x1000 miss.
- R11: A read in the same cycle as a write returns the value held before that write. The write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgRdEn | input | 1 | Configuration read strobe |
| cfgByteEn | input | 4 | Byte lane enables for writes |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read data, same cycle |
| memSpaceEn | input | 1 | Memory decode enable from the command register |
| busAddr | input | 32 | Bus address of the current address phase |
| busCmd | input | 4 | Bus command of the current address phase |
| addrHit | output | 1 | Registered window hit flag |

## Verification
The assertions assume that every input is synchronous to `clk` and settles well before each rising edge. They also assume that `busCmd` is judged only by its value, with no separate address-phase qualifier. The stimulus changes inputs only on falling edges and holds each strobe for one cycle. Random traffic draws bus commands from both memory and non-memory encodings. It places half of the addresses inside or next to the current window, so the hit and miss paths both see frequent traffic.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;
  localparam int BAR_W = 32;
  localparam int LANES = BAR_W / 8;

  typedef enum logic [3:0] {
    CMD_IO_RD  = 4'h2,
    CMD_IO_WR  = 4'h3,
    CMD_MEM_RD = 4'h6,
    CMD_MEM_WR = 4'h7,
    CMD_CFG_RD = 4'hA,
    CMD_CFG_WR = 4'hB
  } bus_cmd_e;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic [LANES-1:0] laneWr;   // per byte lane write strobe
    logic             rdSel;    // drive readback onto the data port
    logic             decodeOn; // memory command with decoding enabled
  } bar_strobe_t;
endpackage

// File: rtl/bar_ctrl.sv
module bar_ctrl
  import pci_bar_pkg::*;
#(
  parameter int WIN_BITS = 12
) (
  input  logic             cfgWrEn,
  input  logic             cfgRdEn,
  input  logic [LANES-1:0] cfgByteEn,
  input  logic             memSpaceEn,
  input  logic [3:0]       busCmd,
  output bar_strobe_t      strobes
);
  logic isMemCmd;

  assign isMemCmd = (busCmd == CMD_MEM_RD) || (busCmd == CMD_MEM_WR);

  // A lane gets a strobe only if it holds at least one writable bit
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    if ((b * 8 + 7) >= WIN_BITS) begin : g_live
      assign strobes.laneWr[b] = cfgWrEn & cfgByteEn[b];
    end else begin : g_dead
      assign strobes.laneWr[b] = 1'b0;
    end
  end

  assign strobes.rdSel    = cfgRdEn;
  assign strobes.decodeOn = memSpaceEn & isMemCmd;
endmodule

// File: rtl/bar_datapath.sv
module bar_datapath
  import pci_bar_pkg::*;
#(
  parameter int WIN_BITS = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  bar_strobe_t      strobes,
  input  logic [BAR_W-1:0] cfgWrData,
  input  logic [BAR_W-1:0] busAddr,
  output logic [BAR_W-1:0] cfgRdData,
  output logic             addrHit
);
  localparam int BASE_W = BAR_W - WIN_BITS;
  // bit0 memory space, bits 2:1 32-bit type, bit3 not prefetchable
  localparam logic [WIN_BITS-1:0] LOW_CONST =
    {{(WIN_BITS-4){1'b0}}, 1'b0, 2'b00, 1'b0};

  logic [BASE_W-1:0] baseQ, baseD;
  logic              hitQ;
  logic              unusedLowBits;

  // Low data and address bits are not stored or compared
  assign unusedLowBits = ^{cfgWrData[WIN_BITS-1:0], busAddr[WIN_BITS-1:0]};

  always_comb begin
    baseD = baseQ;
    for (int i = WIN_BITS; i < BAR_W; i++) begin
      if (strobes.laneWr[i/8]) baseD[i-WIN_BITS] = cfgWrData[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      hitQ  <= 1'b0;
    end else begin
      baseQ <= baseD;
      hitQ  <= strobes.decodeOn && (busAddr[BAR_W-1:WIN_BITS] == baseQ);
    end
  end

  assign cfgRdData = strobes.rdSel ? {baseQ, LOW_CONST} : '0;
  assign addrHit   = hitQ;
endmodule

// File: rtl/pci_mem_bar.sv
module pci_mem_bar
  import pci_bar_pkg::*;
#(
  parameter int WIN_BITS = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgRdEn,
  input  logic [3:0]  cfgByteEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  input  logic        memSpaceEn,
  input  logic [31:0] busAddr,
  input  logic [3:0]  busCmd,
  output logic        addrHit
);
  bar_strobe_t strobes;

  bar_ctrl #(.WIN_BITS(WIN_BITS)) u_ctrl (
    .cfgWrEn   (cfgWrEn),
    .cfgRdEn   (cfgRdEn),
    .cfgByteEn (cfgByteEn),
    .memSpaceEn(memSpaceEn),
    .busCmd    (busCmd),
    .strobes   (strobes)
  );

  bar_datapath #(.WIN_BITS(WIN_BITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfgWrData(cfgWrData),
    .busAddr  (busAddr),
    .cfgRdData(cfgRdData),
    .addrHit  (addrHit)
  );
endmodule

// File: rtl/bar_checker.sv
module bar_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic        cfgRdEn,
  input logic [3:0]  cfgByteEn,
  input logic [31:0] cfgWrData,
  input logic [31:0] cfgRdData,
  input logic        memSpaceEn,
  input logic [31:0] busAddr,
  input logic [3:0]  busCmd,
  input logic        addrHit
);
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdEn |-> cfgRdData == 32'h0);

  p_low_const_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdEn |-> cfgRdData[11:0] == 12'h000);

  p_probe_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgByteEn == 4'hF && cfgWrData == 32'hFFFFFFFF) |=>
      (!cfgRdEn || cfgRdData == 32'hFFFFF000));

  p_lane0_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdEn && $past(cfgRdEn) && $past(cfgByteEn[3:1] == 3'b000))
      |-> cfgRdData == $past(cfgRdData));

  p_enable_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !memSpaceEn |=> !addrHit);

  p_cmd_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(busCmd == 4'h6 || busCmd == 4'h7) |=> !addrHit);

  p_reset_hit_r1: assert property (@(posedge clk)
    !rstN |=> !addrHit);
endmodule

bind pci_mem_bar bar_checker u_chk (.*);

// File: tb/sim_pci_mem_bar.sv
`timescale 1ns/1ps
module sim_pci_mem_bar;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgRdEn = 1'b0;
  logic [3:0]  cfgByteEn = 4'h0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        memSpaceEn = 1'b0;
  logic [31:0] busAddr = '0;
  logic [3:0]  busCmd = 4'h0;
  logic        addrHit;

  int testsRun = 0, testsFailed = 0;
  bit done = 0;
  logic [19:0] expBase = '0;

  pci_mem_bar u0 (.*);

  always #4 clk = ~clk;

  function automatic logic [19:0] applyWrite(logic [19:0] old, logic [31:0] d, logic [3:0] be);
    logic [19:0] n = old;
    if (be[1]) n[3:0]   = d[15:12];
    if (be[2]) n[11:4]  = d[23:16];
    if (be[3]) n[19:12] = d[31:24];
    return n;
  endfunction

  function automatic logic expHit(logic [31:0] a, logic [3:0] c, logic en, logic [19:0] b);
    return en && (c == 4'h6 || c == 4'h7) && (a[31:12] == b);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = d; cfgByteEn = be;
    @(posedge clk);
    expBase = applyWrite(expBase, d, be);
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = 4'h0;
  endtask

  task automatic cfgRead(string req);
    @(negedge clk);
    cfgRdEn = 1'b1;
    #1 check(req, cfgRdData, {expBase, 12'h000});
    @(negedge clk);
    cfgRdEn = 1'b0;
    #1 check("R4 idle", cfgRdData, 32'h0);
  endtask

  task automatic busProbe(string req, logic [31:0] a, logic [3:0] c, logic en);
    logic e;
    @(negedge clk);
    busAddr = a; busCmd = c; memSpaceEn = en;
    e = expHit(a, c, en, expBase);
    @(posedge clk);
    #2 check(req, {31'h0, addrHit}, {31'h0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 hit", {31'h0, addrHit}, 32'h0);
    rstN = 1'b1;
    cfgRead("R1 read");
    busProbe("R1 hit base0", 32'h0000_0010, 4'h6, 1'b1);

    // R2 size probe
    cfgWrite(32'hFFFF_FFFF, 4'hF);
    cfgRead("R2 probe");

    // R6 / R3 assigned base with low bits set
    cfgWrite(32'h0200_0FFF, 4'hF);
    cfgRead("R6 R3 base");

    // R5 lane 0 only: no effect
    cfgWrite(32'hFFFF_FFFF, 4'h1);
    cfgRead("R5 lane0");
    // R5 upper lane only
    cfgWrite(32'hAB00_0000, 4'h8);
    cfgRead("R5 lane3");
    cfgWrite(32'h0200_0000, 4'hF);

    // R11 read during write returns old value
    @(negedge clk);
    cfgWrEn = 1'b1; cfgRdEn = 1'b1; cfgWrData = 32'h1234_5000; cfgByteEn = 4'hF;
    #1 check("R11 old", cfgRdData, 32'h0200_0000);
    @(posedge clk);
    expBase = applyWrite(expBase, 32'h1234_5000, 4'hF);
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = 4'h0;
    #1 check("R11 new", cfgRdData, 32'h1234_5000);
    cfgRdEn = 1'b0;
    cfgWrite(32'h0200_0000, 4'hF);

    // Hit decode
    busProbe("R8 disabled", 32'h0200_0100, 4'h6, 1'b0);
    busProbe("R7 mem rd", 32'h0200_0000, 4'h6, 1'b1);
    busProbe("R7 mem wr", 32'h0200_0ABC, 4'h7, 1'b1);
    busProbe("R10 top", 32'h0200_0FFF, 4'h6, 1'b1);
    busProbe("R10 above", 32'h0200_1000, 4'h6, 1'b1);
    busProbe("R10 below", 32'h01FF_FFFF, 4'h7, 1'b1);
    busProbe("R9 io rd", 32'h0200_0004, 4'h2, 1'b1);
    busProbe("R9 cfg rd", 32'h0200_0004, 4'hA, 1'b1);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 2);
      if (op == 0) begin
        cfgWrite($urandom, 4'($urandom));
      end else if (op == 1) begin
        cfgRead("R6 R5 random read");
      end else begin
        logic [31:0] a;
        logic [3:0] cmds [4] = '{4'h6, 4'h7, 4'h2, 4'hA};
        a = ($urandom_range(0, 1) == 1) ? {expBase, 12'($urandom)} + 32'($urandom_range(0, 2)) * 32'h800 - 32'h800
                                       : $urandom;
        busProbe("R7 R8 R9 random", a, cmds[$urandom_range(0, 3)], $urandom_range(0, 3) != 0);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule